// File: doc/BRIEF.md
# Serial flash identification and status responder

This block is the command layer of a serial flash slave that answers identification and status requests. A byte-level SPI front end handles the bit shifting. It presents each byte received from the host on `rx_byte` with a one-cycle `rx_valid` strobe, and it holds `cs_n` low for the whole frame. The front end shifts out whatever `tx_byte` holds during the next byte slot. The responder therefore updates `tx_byte` one clock after each received byte, so that it holds the reply for the following position in the frame.

Each command has its own byte schedule. The identification commands return fixed identity bytes at fixed positions, after a command-specific number of filler bytes. One of them lets the host choose the order of the two identity bytes. The status reads repeat the same register for as long as the host keeps clocking. A status write is held pending until the host releases chip-select. It is accepted only after a write-enable frame, and it then clears the write-enable latch. The identity values and the power-on status contents are parameters.

Top module: `spi_id_responder`

## Requirements
- R1: After reset, and on the clock after any edge at which `cs_n` is high, `tx_byte` is 0xFF. Status register 1 resets to SR1_INIT with bits 1:0 clear, status register 2 resets to SR2_INIT, and the write-enable latch resets clear.
- R2: Opcode 0x9F returns MFR_ID, MEM_TYPE and DEV_ID in frame bytes 2, 3 and 4, and 0xFF in every later byte.
- R3: Opcode 0xAB returns 0xFF in frame bytes 2 to 4, DEV_ID in byte 5, and 0xFF after byte 5.
- R4: Opcode 0x90 returns 0xFF in bytes 2 to 4. If byte 4 from the host is 0x01, bytes 5 and 6 carry DEV_ID then MFR_ID. For any other value they carry MFR_ID then DEV_ID. Every later byte is 0xFF.
- R5: Opcode 0x05 returns status register 1 in every byte after the opcode until deselect. Bit 1 of that byte is the write-enable latch and bit 0 reads 0.
- R6: Opcode 0x35 returns status register 2 in every byte after the opcode until deselect.
- R7: Opcode 0x06 sets the write-enable latch, and later frames see it.
- R8: With the latch set, opcode 0x01 takes frame byte 2 into status register 1 (bits 7:2 only) and byte 3 into status register 2. Any bytes after byte 3 are ignored. The update happens when `cs_n` rises, and it clears the latch.
- R9: Opcode 0x01 with the latch clear leaves both status registers unchanged.
- R10: Any other opcode returns 0xFF in every byte of its frame.
- R11: A status write that carries only one data byte leaves status register 2 unchanged.
- R12: `rx_valid` strobes while `cs_n` is high have no effect on the replies, the frame position or the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip-select from the front end, active low, synchronous to clk |
| rx_valid | input | 1 | One-cycle strobe: a complete host byte is on rx_byte |
| rx_byte | input | 8 | Byte received from the host |
| tx_byte | output | 8 | Byte to shift out in the next byte slot |

## Verification
The hardest condition to reach is a status write that actually commits. It needs a write-enable in an earlier frame, then a write frame of the right length, then a deselect, and its effect only shows up in a later read frame. The stimulus chains these frames in order: a write without enable first, then one with enable and an extra trailing byte, then a one-byte write. Each is followed by reads of both registers. A behavioural frame model predicts every reply byte on every clock.

// File: rtl/spi_id_responder.sv
module spi_id_responder #(
  parameter logic [7:0] MFR_ID   = 8'hC2,
  parameter logic [7:0] MEM_TYPE = 8'h20,
  parameter logic [7:0] DEV_ID   = 8'h16,
  parameter logic [7:0] SR1_INIT = 8'h00,
  parameter logic [7:0] SR2_INIT = 8'h02
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  output logic [7:0] tx_byte
);
  localparam logic [7:0] OP_JEDEC = 8'h9F;
  localparam logic [7:0] OP_SIG   = 8'hAB;
  localparam logic [7:0] OP_MDID  = 8'h90;
  localparam logic [7:0] OP_RSR1  = 8'h05;
  localparam logic [7:0] OP_RSR2  = 8'h35;
  localparam logic [7:0] OP_WSR   = 8'h01;
  localparam logic [7:0] OP_WEN   = 8'h06;
  localparam logic [2:0] POS_MAX  = 3'd7;

  logic [2:0] pos_q;
  logic [7:0] op_q, ord_q, pend1_q, pend2_q, sr2_q;
  logic [5:0] sr1_q;
  logic       wel_q;
  logic [7:0] resp;

  wire [7:0] op_w      = (pos_q == 3'd0) ? rx_byte : op_q;
  wire [7:0] ord_w     = (pos_q == 3'd3) ? rx_byte : ord_q;
  wire [3:0] nxt       = {1'b0, pos_q} + 4'd2;
  wire       dev_first = (ord_w == 8'h01);
  wire [7:0] sr1_view  = {sr1_q, wel_q, 1'b0};
  wire       commit    = cs_n && (pos_q >= 3'd2) && (op_q == OP_WSR) && wel_q;

  always_comb begin
    resp = 8'hFF;
    case (op_w)
      OP_JEDEC: begin
        if (nxt == 4'd2) resp = MFR_ID;
        else if (nxt == 4'd3) resp = MEM_TYPE;
        else if (nxt == 4'd4) resp = DEV_ID;
      end
      OP_SIG:  if (nxt == 4'd5) resp = DEV_ID;
      OP_MDID: begin
        if (nxt == 4'd5) resp = dev_first ? DEV_ID : MFR_ID;
        else if (nxt == 4'd6) resp = dev_first ? MFR_ID : DEV_ID;
      end
      OP_RSR1: resp = sr1_view;
      OP_RSR2: resp = sr2_q;
      default: resp = 8'hFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q   <= '0;
      op_q    <= '0;
      ord_q   <= '0;
      pend1_q <= '0;
      pend2_q <= '0;
      sr1_q   <= SR1_INIT[7:2];
      sr2_q   <= SR2_INIT;
      wel_q   <= 1'b0;
      tx_byte <= 8'hFF;
    end else if (cs_n) begin
      pos_q   <= '0;
      tx_byte <= 8'hFF;
      if (commit) begin
        sr1_q <= pend1_q[7:2];
        if (pos_q >= 3'd3) sr2_q <= pend2_q;
        wel_q <= 1'b0;
      end
    end else if (rx_valid) begin
      tx_byte <= resp;
      if (pos_q != POS_MAX) pos_q <= pos_q + 3'd1;
      if (pos_q == 3'd0) op_q <= rx_byte;
      if (pos_q == 3'd1) pend1_q <= rx_byte;
      if (pos_q == 3'd2) pend2_q <= rx_byte;
      if (pos_q == 3'd3) ord_q <= rx_byte;
      if (pos_q == 3'd0 && rx_byte == OP_WEN) wel_q <= 1'b1;
    end
  end
endmodule

// File: rtl/spi_id_responder_chk.sv
module spi_id_responder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       rx_valid,
  input logic [7:0] rx_byte,
  input logic [7:0] tx_byte,
  input logic       wel_q,
  input logic [5:0] sr1_q,
  input logic [7:0] sr2_q
);
  a_r1_idle_ff: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (tx_byte == 8'hFF));

  a_r7_wel_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel_q) |-> $past(rx_valid && !cs_n && rx_byte == 8'h06));

  a_r8_sr1_on_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sr1_q) |-> $past(cs_n));

  a_r8_sr2_on_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sr2_q) |-> $past(cs_n));

  a_r8_wel_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sr1_q) || !$stable(sr2_q)) |-> !wel_q);
endmodule

bind spi_id_responder spi_id_responder_chk u_chk (.*);

// File: tb/spi_id_responder_tb.sv
module spi_id_responder_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] MFR = 8'hC2, MEM = 8'h20, DEV = 8'h16;
  localparam logic [7:0] SR1I = 8'h00, SR2I = 8'h02;

  logic clk = 0, rst_n = 0, cs_n = 1, rx_valid = 0;
  logic [7:0] rx_byte = 8'h00;
  wire  [7:0] tx_byte;

  int checks = 0, fails = 0;
  string tag = "R1";
  bit mon_en = 0, done = 0;

  logic [7:0] m_sr1 = {SR1I[7:2], 2'b00};
  logic [7:0] m_sr2 = SR2I;
  bit         m_wel = 0;
  logic [7:0] frame[$];
  logic [7:0] exp_tx = 8'hFF;

  spi_id_responder u_dut (.clk(clk), .rst_n(rst_n), .cs_n(cs_n),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_byte(tx_byte));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string r, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: tx_byte=%02h expected %02h", r, act, exp);
    end
  endtask

  always @(negedge clk) if (mon_en && !done) check(tag, tx_byte, exp_tx);

  function automatic logic [7:0] model_next();
    logic [7:0] op, ord;
    int n;
    op  = frame[0];
    n   = frame.size() + 1;
    ord = (frame.size() >= 4) ? frame[3] : 8'h00;
    case (op)
      8'h9F: return (n == 2) ? MFR : (n == 3) ? MEM : (n == 4) ? DEV : 8'hFF;
      8'hAB: return (n == 5) ? DEV : 8'hFF;
      8'h90: begin
        if (n == 5) return (ord == 8'h01) ? DEV : MFR;
        if (n == 6) return (ord == 8'h01) ? MFR : DEV;
        return 8'hFF;
      end
      8'h05: return {m_sr1[7:2], m_wel, 1'b0};
      8'h35: return m_sr2;
      default: return 8'hFF;
    endcase
  endfunction

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    rx_byte = b; rx_valid = 1;
    @(posedge clk); #1;
    rx_valid = 0;
    if (!cs_n) begin
      frame.push_back(b);
      if (frame.size() == 1 && b == 8'h06) m_wel = 1;
      exp_tx = model_next();
    end
  endtask

  task automatic select();
    @(negedge clk); cs_n = 0;
    @(posedge clk); #1;
  endtask

  task automatic deselect();
    @(negedge clk); cs_n = 1;
    @(posedge clk); #1;
    if (frame.size() >= 2 && frame[0] == 8'h01 && m_wel) begin
      m_sr1 = {frame[1][7:2], 2'b00};
      if (frame.size() >= 3) m_sr2 = frame[2];
      m_wel = 0;
    end
    frame.delete();
    exp_tx = 8'hFF;
  endtask

  task automatic run(input logic [7:0] bytes[$]);
    select();
    foreach (bytes[i]) send(bytes[i]);
    deselect();
    repeat (2) @(posedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    finish_run();
  end

  initial begin
    @(negedge clk); mon_en = 1;
    repeat (2) @(negedge clk);
    rst_n = 1;
    tag = "R1"; repeat (3) @(posedge clk);
    tag = "R2"; run('{8'h9F, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00});
    tag = "R3"; run('{8'hAB, 8'h11, 8'h22, 8'h33, 8'h00, 8'h00, 8'h00});
    tag = "R4"; run('{8'h90, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00});
    tag = "R4"; run('{8'h90, 8'h00, 8'h00, 8'h01, 8'h00, 8'h00, 8'h00});
    tag = "R4"; run('{8'h90, 8'h00, 8'h00, 8'h05, 8'h00, 8'h00});
    tag = "R5"; run('{8'h05, 8'h00, 8'h00, 8'h00, 8'h00});
    tag = "R6"; run('{8'h35, 8'h00, 8'h00, 8'h00});
    tag = "R10"; run('{8'hC7, 8'h00, 8'h00, 8'h00, 8'h00});
    tag = "R9"; run('{8'h01, 8'hFC, 8'h55});
    tag = "R9"; run('{8'h05, 8'h00, 8'h00});
    tag = "R9"; run('{8'h35, 8'h00, 8'h00});
    tag = "R7"; run('{8'h06});
    tag = "R7"; run('{8'h05, 8'h00, 8'h00});
    tag = "R8"; run('{8'h01, 8'hA8, 8'h5A, 8'h77});
    tag = "R8"; run('{8'h05, 8'h00, 8'h00});
    tag = "R8"; run('{8'h35, 8'h00, 8'h00});
    tag = "R11"; run('{8'h06});
    tag = "R11"; run('{8'h01, 8'h3C});
    tag = "R11"; run('{8'h35, 8'h00});
    tag = "R11"; run('{8'h05, 8'h00});
    tag = "R12";
    send(8'h06); send(8'h9F); send(8'h00); send(8'h00);
    repeat (2) @(posedge clk);
    run('{8'h05, 8'h00, 8'h00});
    run('{8'h9F, 8'h00, 8'h00, 8'h00});
    finish_run();
  end
endmodule